// File: doc/BRIEF.md
# Watchdog Reset Gating Controller

This block sits on the power-management side of a chip, next to a watchdog timer. It decides whether the watchdog's expiry request becomes a system reset, and it records whether the last reset came from the watchdog. Software controls it through four one-bit control points:

- a reset gate bit, whose polarity is set by a parameter;
- an auto-suppress bit, which ignores the watchdog while the supervised processor is held in reset;
- a count-enable bit, which drives the watchdog's count gate;
- a sticky cause flag.

To arm the watchdog path, software clears auto-suppress, opens the gate and sets count-enable. It reverses each step to disarm it. The reset pulse that comes out drives the chip's reset sequencer. That sequencer does not reset this block. Only the power-on reset does, so the cause flag can still be read after the reset the block produced.

Top module: `wdt_rst_gate`

## Requirements
- R1: With GATE_INV=0, a gate bit value of 1 blocks every watchdog request, so no pulse appears on `sys_rst` and `rst_cause` does not change. A value of 0 lets requests through.
- R2: With GATE_INV=1, the meaning of the gate bit is reversed. A value of 1 lets requests through and 0 blocks them.
- R3: While the auto-suppress bit is 1 and `cpu_in_rst` is 1, a request produces no pulse. When either of the two is 0, the request is handled normally.
- R4: `cnt_en` equals the count-enable bit, and it changes on the clock edge that follows a write to register 2.
- R5: `rst_cause` becomes 1 in the first cycle of an accepted reset pulse.
- R6: `rst_cause` stays set through and after the pulse. A write of 1 to register 3 clears it, and a write of 0 leaves it unchanged.
- R7: An accepted request is a rising edge of `wdt_req` while the gate is open and the request is not suppressed. Each accepted request raises `sys_rst` for exactly PULSE_CYCLES cycles, and PULSE_CYCLES is at least 4. A held request level, or a new edge that arrives during a pulse, produces no second pulse.
- R8: While `por_n` is low, `sys_rst`, `cnt_en`, auto-suppress and `rst_cause` are 0. The gate bit holds its blocking value: 1 when GATE_INV=0 and 0 when GATE_INV=1.
- R9: If a request is accepted on the same edge as a write of 1 to register 3, the flag ends up set.
- R10: Register addresses are: 0 is the gate bit, 1 is auto-suppress, 2 is count-enable, 3 is the cause flag (write 1 to clear). A write stores `cfg_wdata` in the addressed bit on the clock edge where `cfg_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select (see R10) |
| cfg_wdata | input | 1 | Write data bit |
| wdt_req | input | 1 | Watchdog expiry request, level |
| cpu_in_rst | input | 1 | Supervised processor is held in reset |
| sys_rst | output | 1 | Gated system reset pulse, active high |
| cnt_en | output | 1 | Watchdog count gate |
| gate_bit | output | 1 | Current gate register value |
| auto_sup | output | 1 | Current auto-suppress register value |
| rst_cause | output | 1 | Sticky watchdog-reset cause flag |

## Verification
The bench goes after these corner cases:

- **Held request level.** A design that triggers on the level instead of the edge repeats the pulse; the scoreboard sees this as an unexpected extra item.
- **Second edge during a pulse.** A design that re-arms during a pulse either stretches it or emits two pulses.
- **Suppression inputs one at a time.** Auto-suppress and `cpu_in_rst` are each set alone. Wrong gating either fires while the processor is held in reset, or blocks a legitimate request.
- **Write-0 and write-1 to the cause flag.** Decoding the write data wrongly drops the boot cause.
- **Clear and accept on the same edge.** A design that lets the clear win loses the flag.
- **Inverted-polarity instance and power-on state.** A second instance built with the inverted polarity shows whether the power-on value of the gate bit actually blocks requests.

// File: rtl/wdt_rst_gate.sv
module wdt_rst_gate #(
  parameter bit GATE_INV     = 1'b0,
  parameter int PULSE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_addr,
  input  logic       cfg_wdata,
  input  logic       wdt_req,
  input  logic       cpu_in_rst,
  output logic       sys_rst,
  output logic       cnt_en,
  output logic       gate_bit,
  output logic       auto_sup,
  output logic       rst_cause
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);
  localparam bit GATE_RST = ~GATE_INV;

  initial begin
    if (PULSE_CYCLES < 4) $error("PULSE_CYCLES must be at least 4");
  end

  logic [CW-1:0] pulse_cnt;
  logic          req_d;
  logic          gate_q, sup_q, cen_q, cause_q;

  wire wr_gate  = cfg_we && cfg_addr == 2'd0;
  wire wr_sup   = cfg_we && cfg_addr == 2'd1;
  wire wr_cen   = cfg_we && cfg_addr == 2'd2;
  wire clr_flag = cfg_we && cfg_addr == 2'd3 && cfg_wdata;

  wire open_q   = GATE_INV ? gate_q : ~gate_q;
  wire blocked  = sup_q && cpu_in_rst;
  wire req_edge = wdt_req && !req_d;
  wire busy     = pulse_cnt != '0;
  wire accept   = req_edge && open_q && !blocked && !busy;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      gate_q <= GATE_RST;
      sup_q  <= 1'b0;
      cen_q  <= 1'b0;
    end else begin
      if (wr_gate) gate_q <= cfg_wdata;
      if (wr_sup)  sup_q  <= cfg_wdata;
      if (wr_cen)  cen_q  <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        cause_q <= 1'b0;
    else if (accept)   cause_q <= 1'b1;
    else if (clr_flag) cause_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      req_d     <= 1'b0;
      pulse_cnt <= '0;
    end else begin
      req_d <= wdt_req;
      if (accept)    pulse_cnt <= LOAD;
      else if (busy) pulse_cnt <= pulse_cnt - 1'b1;
    end
  end

  assign sys_rst   = busy;
  assign cnt_en    = cen_q;
  assign gate_bit  = gate_q;
  assign auto_sup  = sup_q;
  assign rst_cause = cause_q;
endmodule

module wdt_rst_gate_chk #(
  parameter bit GATE_INV     = 1'b0,
  parameter int PULSE_CYCLES = 4
) (
  input logic       clk,
  input logic       por_n,
  input logic       cfg_we,
  input logic [1:0] cfg_addr,
  input logic       cfg_wdata,
  input logic       cpu_in_rst,
  input logic       sys_rst,
  input logic       cnt_en,
  input logic       gate_bit,
  input logic       auto_sup,
  input logic       rst_cause
);
  int unsigned hi_len;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       hi_len <= 0;
    else if (sys_rst) hi_len <= hi_len + 1;
    else              hi_len <= 0;
  end

  wire closed = GATE_INV ? !gate_bit : gate_bit;

  p_gate_blocks_r1: assert property (@(posedge clk) disable iff (!por_n)
    closed && !sys_rst |=> !sys_rst);

  p_suppress_r3: assert property (@(posedge clk) disable iff (!por_n)
    auto_sup && cpu_in_rst && !sys_rst |=> !sys_rst);

  p_cnt_follows_r4: assert property (@(posedge clk) disable iff (!por_n)
    cfg_we && cfg_addr == 2'd2 |=> cnt_en == $past(cfg_wdata));

  p_cause_on_pulse_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> rst_cause);

  p_cause_only_by_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_cause) |-> $rose(sys_rst));

  p_pulse_len_r7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> hi_len == PULSE_CYCLES);

  p_no_overlong_r7: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> hi_len < PULSE_CYCLES);
endmodule

bind wdt_rst_gate wdt_rst_gate_chk #(.GATE_INV(GATE_INV), .PULSE_CYCLES(PULSE_CYCLES)) u_chk (
  .clk(clk), .por_n(por_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .cpu_in_rst(cpu_in_rst), .sys_rst(sys_rst),
  .cnt_en(cnt_en), .gate_bit(gate_bit), .auto_sup(auto_sup),
  .rst_cause(rst_cause));

// File: tb/test_wdt_rst_gate.sv
module test_wdt_rst_gate;
  localparam int PC = 4;

  logic clk = 0;
  logic por_n = 0;
  logic cfg_we = 0, cfg_wdata = 0;
  logic [1:0] cfg_addr = 0;
  logic wdt_req = 0, cpu_in_rst = 0;
  logic sys_rst, cnt_en, gate_bit, auto_sup, rst_cause;

  logic iv_we = 0, iv_wdata = 0;
  logic [1:0] iv_addr = 0;
  logic iv_rst, iv_cen, iv_gate, iv_sup, iv_cause;

  int total = 0, bad = 0;
  int exp_q[$];
  int cur_len = 0;
  int iv_pulses = 0;
  bit iv_prev = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  wdt_rst_gate #(.GATE_INV(1'b0), .PULSE_CYCLES(PC)) i_wdt_rst_gate (
    .clk(clk), .por_n(por_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wdt_req(wdt_req), .cpu_in_rst(cpu_in_rst),
    .sys_rst(sys_rst), .cnt_en(cnt_en), .gate_bit(gate_bit),
    .auto_sup(auto_sup), .rst_cause(rst_cause));

  wdt_rst_gate #(.GATE_INV(1'b1), .PULSE_CYCLES(PC)) i_wdt_rst_gate_inv (
    .clk(clk), .por_n(por_n), .cfg_we(iv_we), .cfg_addr(iv_addr),
    .cfg_wdata(iv_wdata), .wdt_req(wdt_req), .cpu_in_rst(cpu_in_rst),
    .sys_rst(iv_rst), .cnt_en(iv_cen), .gate_bit(iv_gate),
    .auto_sup(iv_sup), .rst_cause(iv_cause));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (iv_rst && !iv_prev) iv_pulses++;
    iv_prev = iv_rst;
    if (sys_rst) cur_len++;
    else if (cur_len != 0) begin
      if (exp_q.size() == 0)
        chk(0, "R7 unexpected pulse", cur_len, 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(cur_len == e, "R7 pulse length", cur_len, e);
      end
      cur_len = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fire(input bit expect_pulse);
    @(negedge clk);
    wdt_req = 1;
    if (expect_pulse) exp_q.push_back(PC);
    @(negedge clk);
    wdt_req = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog timeout actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sys_rst == 0 && cnt_en == 0 && auto_sup == 0 && rst_cause == 0, "R8 reset outputs",
        {sys_rst, cnt_en, auto_sup, rst_cause}, 0);
    chk(gate_bit == 1, "R8 gate blocks at reset", gate_bit, 1);
    chk(iv_gate == 0, "R8 inverted gate at reset", iv_gate, 0);
    por_n = 1;
    @(negedge clk);

    fire(0);
    chk(rst_cause == 0, "R1 blocked request leaves flag", rst_cause, 0);
    chk(iv_pulses == 0, "R2 inverted blocked at 0", iv_pulses, 0);

    // turn-on sequence: clear suppress, open gate, enable counting
    wr(2'd1, 0);
    wr(2'd0, 0);
    chk(gate_bit == 0, "R10 gate write", gate_bit, 0);
    wr(2'd2, 1);
    chk(cnt_en == 1, "R4 count enable set", cnt_en, 1);

    fire(1);
    drain("R7 accepted pulse seen");
    chk(rst_cause == 1, "R5 flag set by pulse", rst_cause, 1);
    repeat (5) @(negedge clk);
    chk(rst_cause == 1, "R6 flag sticky", rst_cause, 1);
    wr(2'd3, 0);
    chk(rst_cause == 1, "R6 write 0 no effect", rst_cause, 1);
    wr(2'd3, 1);
    chk(rst_cause == 0, "R6 write 1 clears", rst_cause, 0);

    // held level: one pulse only
    @(negedge clk);
    wdt_req = 1;
    exp_q.push_back(PC);
    repeat (12) @(negedge clk);
    wdt_req = 0;
    repeat (4) @(negedge clk);
    drain("R7 held level single pulse");

    // second edge inside the pulse is ignored
    @(negedge clk);
    wdt_req = 1; exp_q.push_back(PC);
    @(negedge clk); wdt_req = 0;
    @(negedge clk); wdt_req = 1;
    @(negedge clk); wdt_req = 0;
    repeat (10) @(negedge clk);
    drain("R7 edge during pulse ignored");

    // auto-suppress
    wr(2'd3, 1);
    wr(2'd1, 1);
    chk(auto_sup == 1, "R10 suppress write", auto_sup, 1);
    cpu_in_rst = 1;
    fire(0);
    chk(rst_cause == 0, "R3 suppressed while cpu in reset", rst_cause, 0);
    cpu_in_rst = 0;
    fire(1);
    drain("R3 suppress bit alone passes");
    wr(2'd1, 0);
    cpu_in_rst = 1;
    fire(1);
    drain("R3 cpu in reset alone passes");
    cpu_in_rst = 0;

    // set wins over clear on the same edge
    repeat (4) @(negedge clk);
    cfg_we = 1; cfg_addr = 2'd3; cfg_wdata = 1;
    wdt_req = 1; exp_q.push_back(PC);
    @(negedge clk);
    cfg_we = 0; wdt_req = 0;
    chk(rst_cause == 1, "R9 set beats clear", rst_cause, 1);
    repeat (8) @(negedge clk);
    drain("R9 pulse issued");

    // inverted polarity instance: open with 1
    @(negedge clk);
    iv_we = 1; iv_addr = 2'd0; iv_wdata = 1;
    @(negedge clk);
    iv_we = 0;
    fire(1);
    chk(iv_pulses == 1, "R2 inverted passes at 1", iv_pulses, 1);
    chk(iv_cause == 1, "R2 inverted flag", iv_cause, 1);
    drain("R2 main pulse alongside");

    // turn-off sequence: close gate, disable counting
    wr(2'd3, 1);
    wr(2'd0, 1);
    wr(2'd2, 0);
    chk(cnt_en == 0, "R4 count enable cleared", cnt_en, 0);
    fire(0);
    chk(rst_cause == 0, "R1 gate closed again", rst_cause, 0);

    // power-on reset restores everything
    wr(2'd0, 0);
    wr(2'd2, 1);
    wr(2'd1, 1);
    fire(1);
    drain("R7 pulse before por");
    @(negedge clk);
    por_n = 0;
    @(negedge clk);
    chk(cnt_en == 0 && auto_sup == 0 && rst_cause == 0 && gate_bit == 1,
        "R8 por clears controls", {cnt_en, auto_sup, rst_cause, gate_bit}, 1);
    por_n = 1;
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && cur_len == 0, "R7 no stray pulses", exp_q.size(), 0);
    summary();
  end
endmodule